// File: doc/BRIEF.md
# Supervisor Trap Entry and Return Controller

This block performs the hardware side of taking a trap into supervisor mode and leaving it again, for a single hart of a small RISC-V-style core. Each cycle it looks at the exception request from the pipeline and at three interrupt lines: software, timer and external. If a trap is due, it records the interrupted state in its supervisor CSRs, which are the vector base, exception PC, cause, trap value, scratch and three status bits. One cycle later it presents a redirect to the handler address together with supervisor privilege. On an sret strobe it redirects to the saved exception PC and restores the privilege recorded at entry.

Entry is kept deliberately small. Interrupts are gated by the interrupt-enable bit and exceptions are not. The block saves the PC, the previous mode, the previous enable and the cause. It never touches address translation, the stack or the general registers; that is left to handler software. A CSR port with a 3-bit register select gives supervisor code read and write access. The same access from user mode is refused.

Top module: `strap_unit`

## Requirements
- R1: An exception request (`exc_req`) is always taken. An interrupt is taken only while the status enable bit (status bit 1) is set. When both are present in the same cycle, the exception is taken.
- R2: A trap decided in cycle N gives, after the clock edge ending N, `trap_taken`=1 for exactly one cycle, `redirect_valid`=1, `redirect_pc` equal to the vector register as it was in cycle N, and `new_priv`=1 (supervisor).
- R3: On entry, the exception PC becomes `cur_pc` with bits [1:0] cleared. The status bits change as follows: previous-mode (bit 8) takes `cur_priv` (0 user, 1 supervisor), previous-enable (bit 5) takes the old enable bit, and the enable bit (bit 1) is cleared.
- R4: The cause register holds bit 31 = 1 for an interrupt and 0 for an exception, with the code in bits [4:0] and zeros elsewhere. Interrupt codes are 1 software, 5 timer and 9 external. Exception codes are passed through unchanged, for example 8 for an environment call from user mode, 9 for one from supervisor mode, 2 for an illegal instruction and 3 for a breakpoint.
- R5: With several interrupt lines pending, external is taken before software, and software before timer.
- R6: The trap value register receives `exc_addr` for exception codes 12, 13 and 15 (page faults). It receives 0 for any other exception and for interrupts.
- R7: sret with no trap in the same cycle redirects to the exception PC with `new_priv` equal to the previous-mode bit. It then sets enable to the old previous-enable, sets previous-enable to 1 and clears previous-mode. A trap in the same cycle takes priority over sret.
- R8: A CSR access (`csr_en`) while `cur_priv`=0 raises `csr_fault`, reads as 0 and changes no register.
- R9: The CSR select values are 0 status, 1 vector, 2 scratch, 3 exception PC, 4 cause and 5 trap value. Vector and exception-PC bits [1:0] always read 0.
- R10: A CSR write in the same cycle as a trap is overridden by the trap in the registers the trap updates. A write to any other register still takes effect.
- R11: After reset, all CSRs read 0, `redirect_valid`=0, `trap_taken`=0 and `new_priv`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | XLEN | PC of the instruction being interrupted |
| cur_priv | input | 1 | Current mode, 0 user, 1 supervisor |
| exc_req | input | 1 | Exception request this cycle |
| exc_code | input | 5 | Exception cause code |
| exc_addr | input | XLEN | Faulting virtual address |
| irq_soft | input | 1 | Supervisor software interrupt pending |
| irq_timer | input | 1 | Supervisor timer interrupt pending |
| irq_ext | input | 1 | Supervisor external interrupt pending |
| ret_req | input | 1 | sret strobe |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR access is a write |
| csr_sel | input | 3 | CSR select |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| csr_fault | output | 1 | Illegal (user-mode) CSR access |
| redirect_valid | output | 1 | Redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| new_priv | output | 1 | Mode after the redirect |
| trap_taken | output | 1 | One-cycle trap pulse |

## Verification
The hardest situations to reach are collisions within a single cycle: a trap arriving together with a CSR write, or together with sret. In both cases the trap must win only where it actually writes. The bench drives these coincidences directly, for example an exception together with a write to the exception PC, and an exception together with a scratch write. It then reads back through the CSR port. Interrupt masking is reached by first writing the enable bit through the status register in supervisor mode and only then raising the lines, so each table row starts from a known enable state.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic {
        PRIV_USER  = 1'b0,
        PRIV_SUPER = 1'b1
    } priv_e;

    typedef enum logic [2:0] {
        CSEL_STATUS  = 3'd0,
        CSEL_VEC     = 3'd1,
        CSEL_SCRATCH = 3'd2,
        CSEL_EPC     = 3'd3,
        CSEL_CAUSE   = 3'd4,
        CSEL_TVAL    = 3'd5
    } csr_sel_e;

    localparam int unsigned CODE_W      = 5;
    localparam int unsigned NUM_IRQ_SRC = 3;
    localparam int unsigned ST_SIE_POS  = 1;
    localparam int unsigned ST_SPIE_POS = 5;
    localparam int unsigned ST_SPP_POS  = 8;

    localparam logic [CODE_W-1:0] IRQ_CODE_SOFT  = 5'd1;
    localparam logic [CODE_W-1:0] IRQ_CODE_TIMER = 5'd5;
    localparam logic [CODE_W-1:0] IRQ_CODE_EXT   = 5'd9;
    localparam logic [CODE_W-1:0] EXC_INST_PF    = 5'd12;
    localparam logic [CODE_W-1:0] EXC_LOAD_PF    = 5'd13;
    localparam logic [CODE_W-1:0] EXC_STORE_PF   = 5'd15;
endpackage

// File: rtl/strap_arbiter.sv
module strap_arbiter
    import strap_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_IRQ_SRC
) (
    input  logic [N_SRC-1:0]  irq_lines,
    input  logic              sie,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              ret_req,
    output logic              trap_take,
    output logic              trap_is_irq,
    output logic [CODE_W-1:0] trap_code,
    output logic              ret_take
);
    // irq_lines index 0 has the highest priority: external, software, timer
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            0:       return IRQ_CODE_EXT;
            1:       return IRQ_CODE_SOFT;
            default: return IRQ_CODE_TIMER;
        endcase
    endfunction

    logic              irq_hit;
    logic [CODE_W-1:0] irq_code;
    logic              irq_take;

    always_comb begin
        irq_hit  = 1'b0;
        irq_code = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (irq_lines[i]) begin
                irq_hit  = 1'b1;
                irq_code = src_code(i);
            end
        end
    end

    always_comb begin
        irq_take    = irq_hit & sie & ~exc_req;
        trap_take   = exc_req | irq_take;
        trap_is_irq = irq_take;
        trap_code   = exc_req ? exc_code : irq_code;
        ret_take    = ret_req & ~trap_take;
    end
endmodule

// File: rtl/strap_csr_file.sv
module strap_csr_file
    import strap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_take,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              cur_priv,
    input  logic [XLEN-1:0]   exc_addr,
    input  logic              ret_take,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   vec_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   scratch_o,
    output logic              sie_o,
    output logic              spie_o,
    output logic              spp_o
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);
    localparam int unsigned     CAUSE_PAD  = XLEN - 1 - CODE_W;

    typedef struct packed {
        logic [XLEN-1:0] vec;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
        logic [XLEN-1:0] scratch;
        logic            sie;
        logic            spie;
        logic            spp;
    } csr_state_t;

    csr_state_t st_d, st_q;
    logic       is_pf;

    always_comb begin
        st_d  = st_q;
        is_pf = (trap_code == EXC_INST_PF) || (trap_code == EXC_LOAD_PF) ||
                (trap_code == EXC_STORE_PF);
        if (wr_en) begin
            case (csr_sel_e'(sel))
                CSEL_STATUS: begin
                    st_d.sie  = wdata[ST_SIE_POS];
                    st_d.spie = wdata[ST_SPIE_POS];
                    st_d.spp  = wdata[ST_SPP_POS];
                end
                CSEL_VEC:     st_d.vec     = wdata & ALIGN_MASK;
                CSEL_SCRATCH: st_d.scratch = wdata;
                CSEL_EPC:     st_d.epc     = wdata & ALIGN_MASK;
                CSEL_CAUSE:   st_d.cause   = wdata;
                CSEL_TVAL:    st_d.tval    = wdata;
                default: ;
            endcase
        end
        if (trap_take) begin
            st_d.epc   = cur_pc & ALIGN_MASK;
            st_d.cause = {trap_is_irq, {CAUSE_PAD{1'b0}}, trap_code};
            st_d.tval  = (!trap_is_irq && is_pf) ? exc_addr : '0;
            st_d.spp   = cur_priv;
            st_d.spie  = st_q.sie;
            st_d.sie   = 1'b0;
        end else if (ret_take) begin
            st_d.sie  = st_q.spie;
            st_d.spie = 1'b1;
            st_d.spp  = PRIV_USER;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (csr_sel_e'(sel))
            CSEL_STATUS: begin
                rdata[ST_SIE_POS]  = st_q.sie;
                rdata[ST_SPIE_POS] = st_q.spie;
                rdata[ST_SPP_POS]  = st_q.spp;
            end
            CSEL_VEC:     rdata = st_q.vec;
            CSEL_SCRATCH: rdata = st_q.scratch;
            CSEL_EPC:     rdata = st_q.epc;
            CSEL_CAUSE:   rdata = st_q.cause;
            CSEL_TVAL:    rdata = st_q.tval;
            default:      rdata = '0;
        endcase
    end

    assign vec_o     = st_q.vec;
    assign epc_o     = st_q.epc;
    assign cause_o   = st_q.cause;
    assign scratch_o = st_q.scratch;
    assign sie_o     = st_q.sie;
    assign spie_o    = st_q.spie;
    assign spp_o     = st_q.spp;
endmodule

// File: rtl/strap_redirect.sv
module strap_redirect
    import strap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_take,
    input  logic            ret_take,
    input  logic [XLEN-1:0] vec,
    input  logic [XLEN-1:0] epc,
    input  logic            spp,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            new_priv,
    output logic            trap_taken
);
    typedef struct packed {
        logic            valid;
        logic            pulse;
        logic [XLEN-1:0] pc;
        logic            priv;
    } redir_t;

    redir_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = trap_take | ret_take;
        rd_d.pulse = trap_take;
        if (trap_take) begin
            rd_d.pc   = vec;
            rd_d.priv = PRIV_SUPER;
        end else if (ret_take) begin
            rd_d.pc   = epc;
            rd_d.priv = spp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q       <= '0;
            rd_q.priv  <= PRIV_SUPER;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign redirect_valid = rd_q.valid;
    assign redirect_pc    = rd_q.pc;
    assign new_priv       = rd_q.priv;
    assign trap_taken     = rd_q.pulse;
endmodule

// File: rtl/strap_unit.sv
module strap_unit
    import strap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              cur_priv,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_addr,
    input  logic              irq_soft,
    input  logic              irq_timer,
    input  logic              irq_ext,
    input  logic              ret_req,
    input  logic              csr_en,
    input  logic              csr_we,
    input  logic [2:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_fault,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              new_priv,
    output logic              trap_taken
);
    logic              trap_take_w, trap_is_irq_w, ret_take_w;
    logic [CODE_W-1:0] trap_code_w;
    logic              csr_ok_w, csr_wr_w;
    logic [XLEN-1:0]   file_rdata_w;
    logic [XLEN-1:0]   vec_w, epc_w, cause_w, scratch_w;
    logic              sie_w, spie_w, spp_w;

    assign csr_ok_w  = (cur_priv == PRIV_SUPER);
    assign csr_wr_w  = csr_en & csr_we & csr_ok_w;
    assign csr_fault = csr_en & ~csr_ok_w;
    assign csr_rdata = (csr_en & csr_ok_w) ? file_rdata_w : '0;

    strap_arbiter #(.N_SRC(NUM_IRQ_SRC)) u_arb (
        .irq_lines   ({irq_timer, irq_soft, irq_ext}),
        .sie         (sie_w),
        .exc_req     (exc_req),
        .exc_code    (exc_code),
        .ret_req     (ret_req),
        .trap_take   (trap_take_w),
        .trap_is_irq (trap_is_irq_w),
        .trap_code   (trap_code_w),
        .ret_take    (ret_take_w)
    );

    strap_csr_file #(.XLEN(XLEN)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_take   (trap_take_w),
        .trap_is_irq (trap_is_irq_w),
        .trap_code   (trap_code_w),
        .cur_pc      (cur_pc),
        .cur_priv    (cur_priv),
        .exc_addr    (exc_addr),
        .ret_take    (ret_take_w),
        .wr_en       (csr_wr_w),
        .sel         (csr_sel),
        .wdata       (csr_wdata),
        .rdata       (file_rdata_w),
        .vec_o       (vec_w),
        .epc_o       (epc_w),
        .cause_o     (cause_w),
        .scratch_o   (scratch_w),
        .sie_o       (sie_w),
        .spie_o      (spie_w),
        .spp_o       (spp_w)
    );

    strap_redirect #(.XLEN(XLEN)) u_redir (
        .clk            (clk),
        .rst_n          (rst_n),
        .trap_take      (trap_take_w),
        .ret_take       (ret_take_w),
        .vec            (vec_w),
        .epc            (epc_w),
        .spp            (spp_w),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .new_priv       (new_priv),
        .trap_taken     (trap_taken)
    );
endmodule

// File: rtl/strap_unit_chk.sv
module strap_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] cur_pc,
    input logic            cur_priv,
    input logic            exc_req,
    input logic            irq_soft,
    input logic            irq_timer,
    input logic            irq_ext,
    input logic            ret_req,
    input logic            csr_en,
    input logic            csr_we,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic            new_priv,
    input logic            trap_taken,
    input logic [XLEN-1:0] vec,
    input logic [XLEN-1:0] epc,
    input logic [XLEN-1:0] cause,
    input logic [XLEN-1:0] scratch,
    input logic            sie,
    input logic            spie,
    input logic            spp
);
    logic irq_any;
    assign irq_any = irq_soft | irq_timer | irq_ext;

    assert_exc_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> trap_taken);

    assert_irq_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req && !sie) |=> !trap_taken);

    assert_entry_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || (irq_any && sie)) |=>
            (trap_taken && redirect_valid && new_priv && redirect_pc == $past(vec)));

    assert_entry_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || (irq_any && sie)) |=>
            (!sie && spie == $past(sie) && spp == $past(cur_priv) &&
             epc == ($past(cur_pc) & ~XLEN'(3))));

    assert_cause_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || (irq_any && sie)) |=> (cause[XLEN-1] == !$past(exc_req)));

    assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !exc_req && !(irq_any && sie)) |=>
            (redirect_valid && !trap_taken && redirect_pc == $past(epc) &&
             new_priv == $past(spp) && sie == $past(spie) && spie && !spp));

    assert_user_csr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_we && !cur_priv) |=> (scratch == $past(scratch)));
endmodule

bind strap_unit strap_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cur_pc         (cur_pc),
    .cur_priv       (cur_priv),
    .exc_req        (exc_req),
    .irq_soft       (irq_soft),
    .irq_timer      (irq_timer),
    .irq_ext        (irq_ext),
    .ret_req        (ret_req),
    .csr_en         (csr_en),
    .csr_we         (csr_we),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .new_priv       (new_priv),
    .trap_taken     (trap_taken),
    .vec            (vec_w),
    .epc            (epc_w),
    .cause          (cause_w),
    .scratch        (scratch_w),
    .sie            (sie_w),
    .spie           (spie_w),
    .spp            (spp_w)
);

// File: tb/strap_unit_tb_top.sv
`timescale 1ns/1ps
module strap_unit_tb_top;
    localparam int XLEN = 32;
    localparam logic [2:0] S_STATUS = 3'd0, S_VEC = 3'd1, S_SCR = 3'd2,
                           S_EPC = 3'd3, S_CAUSE = 3'd4, S_TVAL = 3'd5;
    localparam logic [31:0] VEC_WR = 32'h8000_0103;
    localparam logic [31:0] VEC_RD = 32'h8000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [XLEN-1:0] cur_pc = '0, exc_addr = '0, csr_wdata = '0;
    logic cur_priv = 1'b1, exc_req = 1'b0, ret_req = 1'b0;
    logic [4:0] exc_code = '0;
    logic irq_soft = 1'b0, irq_timer = 1'b0, irq_ext = 1'b0;
    logic csr_en = 1'b0, csr_we = 1'b0;
    logic [2:0] csr_sel = '0;
    logic [XLEN-1:0] csr_rdata, redirect_pc;
    logic csr_fault, redirect_valid, new_priv, trap_taken;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    strap_unit #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_priv(cur_priv),
        .exc_req(exc_req), .exc_code(exc_code), .exc_addr(exc_addr),
        .irq_soft(irq_soft), .irq_timer(irq_timer), .irq_ext(irq_ext),
        .ret_req(ret_req), .csr_en(csr_en), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_fault(csr_fault),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .new_priv(new_priv), .trap_taken(trap_taken)
    );

    typedef struct packed {
        logic        exc;
        logic [4:0]  code;
        logic [2:0]  irq;   // {ext, soft, timer}
        logic        priv;
        logic        sie;
        logic [31:0] pc;
        logic [31:0] addr;
        logic        take;
        logic [31:0] cause;
        logic [31:0] tval;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 5'd8,  3'b000, 1'b0, 1'b1, 32'h0000_1003, 32'h0,          1'b1, 32'd8,          32'h0},
        '{1'b1, 5'd9,  3'b000, 1'b1, 1'b0, 32'h0000_2000, 32'h0,          1'b1, 32'd9,          32'h0},
        '{1'b1, 5'd13, 3'b000, 1'b0, 1'b1, 32'h0000_3002, 32'hDEAD_BEEF,  1'b1, 32'd13,         32'hDEAD_BEEF},
        '{1'b1, 5'd15, 3'b000, 1'b1, 1'b1, 32'h0000_4000, 32'h1234_5678,  1'b1, 32'd15,         32'h1234_5678},
        '{1'b1, 5'd12, 3'b000, 1'b0, 1'b0, 32'h0000_5004, 32'h0000_5004,  1'b1, 32'd12,         32'h0000_5004},
        '{1'b1, 5'd2,  3'b000, 1'b0, 1'b1, 32'h0000_6000, 32'hFFFF_0000,  1'b1, 32'd2,          32'h0},
        '{1'b0, 5'd0,  3'b001, 1'b0, 1'b1, 32'h0000_7000, 32'h0,          1'b1, 32'h8000_0005,  32'h0},
        '{1'b0, 5'd0,  3'b001, 1'b0, 1'b0, 32'h0000_7100, 32'h0,          1'b0, 32'h0,          32'h0},
        '{1'b0, 5'd0,  3'b011, 1'b1, 1'b1, 32'h0000_7200, 32'h0,          1'b1, 32'h8000_0001,  32'h0},
        '{1'b0, 5'd0,  3'b111, 1'b0, 1'b1, 32'h0000_7300, 32'h0,          1'b1, 32'h8000_0009,  32'h0},
        '{1'b0, 5'd0,  3'b100, 1'b0, 1'b0, 32'h0000_7400, 32'h0,          1'b0, 32'h0,          32'h0},
        '{1'b1, 5'd13, 3'b100, 1'b0, 1'b1, 32'h0000_7500, 32'hAAAA_0000,  1'b1, 32'd13,         32'hAAAA_0000},
        '{1'b1, 5'd3,  3'b000, 1'b0, 1'b1, 32'h0000_7601, 32'h0,          1'b1, 32'd3,          32'h0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic csr_wr(input logic [2:0] s, input logic [31:0] d);
        cur_priv = 1'b1; csr_en = 1'b1; csr_we = 1'b1; csr_sel = s; csr_wdata = d;
        tick();
        csr_en = 1'b0; csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [2:0] s, output logic [31:0] d);
        cur_priv = 1'b1; csr_en = 1'b1; csr_we = 1'b0; csr_sel = s;
        #1;
        d = csr_rdata;
        csr_en = 1'b0;
    endtask

    task automatic clear_stim();
        exc_req = 1'b0; irq_ext = 1'b0; irq_soft = 1'b0; irq_timer = 1'b0;
        ret_req = 1'b0; csr_en = 1'b0; csr_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) tick();
        // R11 reset state
        chk(redirect_valid == 1'b0, "R11 redirect_valid", 32'(redirect_valid), 32'h0);
        chk(trap_taken == 1'b0, "R11 trap_taken", 32'(trap_taken), 32'h0);
        chk(new_priv == 1'b1, "R11 new_priv", 32'(new_priv), 32'h1);
        rst_n = 1'b1;
        tick();
        for (int s = 0; s < 6; s++) begin
            csr_rd(3'(s), rv);
            chk(rv == 32'h0, "R11 csr reset value", rv, 32'h0);
        end

        // R9 vector alignment
        csr_wr(S_VEC, VEC_WR);
        csr_rd(S_VEC, rv);
        chk(rv == VEC_RD, "R9 vector low bits", rv, VEC_RD);

        // Table of traps: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            csr_wr(S_STATUS, 32'(TBL[i].sie) << 1);
            cur_priv = TBL[i].priv; cur_pc = TBL[i].pc;
            exc_req = TBL[i].exc; exc_code = TBL[i].code; exc_addr = TBL[i].addr;
            irq_ext = TBL[i].irq[2]; irq_soft = TBL[i].irq[1]; irq_timer = TBL[i].irq[0];
            tick();
            clear_stim();
            chk(trap_taken == TBL[i].take, "R1 trap decision", 32'(trap_taken), 32'(TBL[i].take));
            if (TBL[i].take) begin
                chk(redirect_valid && redirect_pc == VEC_RD, "R2 redirect target", redirect_pc, VEC_RD);
                chk(new_priv == 1'b1, "R2 new_priv", 32'(new_priv), 32'h1);
                csr_rd(S_CAUSE, rv);
                chk(rv == TBL[i].cause, "R4 R5 cause", rv, TBL[i].cause);
                csr_rd(S_TVAL, rv);
                chk(rv == TBL[i].tval, "R6 trap value", rv, TBL[i].tval);
                csr_rd(S_EPC, rv);
                chk(rv == (TBL[i].pc & ~32'h3), "R3 exception pc", rv, TBL[i].pc & ~32'h3);
                csr_rd(S_STATUS, rv);
                chk(rv == ((32'(TBL[i].sie) << 5) | (32'(TBL[i].priv) << 8)), "R3 status on entry",
                    rv, (32'(TBL[i].sie) << 5) | (32'(TBL[i].priv) << 8));
            end else begin
                chk(redirect_valid == 1'b0, "R1 no redirect when masked", 32'(redirect_valid), 32'h0);
                csr_rd(S_STATUS, rv);
                chk(rv == (32'(TBL[i].sie) << 1), "R1 status untouched", rv, 32'(TBL[i].sie) << 1);
            end
            tick();
            chk(trap_taken == 1'b0, "R2 single pulse", 32'(trap_taken), 32'h0);
        end

        // R7 sret back to supervisor
        csr_wr(S_EPC, 32'h0000_2002);
        csr_wr(S_STATUS, 32'h0000_0120);
        ret_req = 1'b1;
        tick();
        clear_stim();
        chk(redirect_valid && redirect_pc == 32'h0000_2000, "R7 sret target", redirect_pc, 32'h0000_2000);
        chk(new_priv == 1'b1 && trap_taken == 1'b0, "R7 sret mode S", 32'(new_priv), 32'h1);
        csr_rd(S_STATUS, rv);
        chk(rv == 32'h0000_0022, "R7 status after sret", rv, 32'h0000_0022);
        // R7 sret back to user
        csr_wr(S_STATUS, 32'h0000_0000);
        ret_req = 1'b1;
        tick();
        clear_stim();
        chk(new_priv == 1'b0, "R7 sret mode U", 32'(new_priv), 32'h0);
        csr_rd(S_STATUS, rv);
        chk(rv == 32'h0000_0020, "R7 status after sret U", rv, 32'h0000_0020);
        // R7 trap wins over sret
        tick();
        cur_priv = 1'b1; cur_pc = 32'h0000_9000; exc_req = 1'b1; exc_code = 5'd9; ret_req = 1'b1;
        tick();
        clear_stim();
        chk(trap_taken && redirect_pc == VEC_RD, "R7 trap beats sret", redirect_pc, VEC_RD);

        // R8 user-mode CSR access
        csr_wr(S_SCR, 32'h1111_2222);
        cur_priv = 1'b0; csr_en = 1'b1; csr_we = 1'b1; csr_sel = S_SCR; csr_wdata = 32'hFFFF_FFFF;
        #1;
        chk(csr_fault == 1'b1, "R8 fault flag", 32'(csr_fault), 32'h1);
        chk(csr_rdata == 32'h0, "R8 read zero", csr_rdata, 32'h0);
        tick();
        clear_stim();
        csr_rd(S_SCR, rv);
        chk(rv == 32'h1111_2222, "R8 scratch unchanged", rv, 32'h1111_2222);
        chk(csr_fault == 1'b0, "R8 no fault in S", 32'(csr_fault), 32'h0);

        // R10 trap and CSR write in the same cycle
        cur_priv = 1'b1; cur_pc = 32'h0000_3004; exc_req = 1'b1; exc_code = 5'd8;
        csr_en = 1'b1; csr_we = 1'b1; csr_sel = S_EPC; csr_wdata = 32'h0000_5554;
        tick();
        clear_stim();
        csr_rd(S_EPC, rv);
        chk(rv == 32'h0000_3004, "R10 trap wins epc", rv, 32'h0000_3004);
        cur_pc = 32'h0000_3100; exc_req = 1'b1; exc_code = 5'd2;
        csr_en = 1'b1; csr_we = 1'b1; csr_sel = S_SCR; csr_wdata = 32'h0000_ABCD;
        tick();
        clear_stim();
        csr_rd(S_SCR, rv);
        chk(rv == 32'h0000_ABCD, "R10 scratch still written", rv, 32'h0000_ABCD);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule